// File: doc/BRIEF.md
# Debug Link Serial Receiver

This block receives asynchronous serial bytes on a debug link. A baud generator inside it is programmed with one reload number: the count of system clocks that span eight data bits. One bit time is therefore that number divided by eight. An accumulator adds eight each system clock and produces a bit tick each time its sum reaches the reload number. The remainder is carried into the next bit, so a fractional bit time causes no drift across the frame.

The receiver waits for a falling edge on the synchronized line. It confirms the start bit half a bit later, then samples eight data bits, least significant bit first, at their middles. It then samples the stop bit at its middle. It reports the byte with a one-clock strobe and flags a low stop sample as a framing error. The receiver returns to hunting for the next start bit right after the mid-stop sample, which absorbs rate skew between the sender and the receiver. In debug mode, only the low 12 bits of the reload number are used.

Top module: `dbg_serial_rx`

## Requirements
- R1: After reset, `rx_valid` and `frame_err` are 0, `rx_byte` is 0, the line is treated as idle High, and the reload number is 128 (16 clocks per bit) until the first write.
- R2: One bit time equals the effective reload number divided by 8 system clocks, averaged over the frame through an add-8 accumulator that carries its remainder. Bit ticks never fall on two consecutive clocks.
- R3: When `dbg_mode` is 1, the effective reload number is bits 11..0 of the stored value. When it is 0, all 16 bits are used.
- R4: An effective reload number below 32 is raised to 32, so the fastest bit time is 4 clocks.
- R5: A one-clock pulse on `reload_we` stores the 16-bit `reload_val`, and later frames use the new rate.
- R6: Data bits are assembled least significant bit first. `rx_valid` is High for exactly one clock per frame, at the mid-stop sample, with the byte on `rx_byte`.
- R7: A Low mid-stop sample sets `frame_err` High in the same cycle as `rx_valid`. A High sample leaves it 0. `frame_err` is never High without `rx_valid`.
- R8: A falling edge whose line is High again at the half-bit check is dropped. No frame is reported.
- R9: The receiver goes back to idle in the clock after the mid-stop sample. A next start bit that begins 0.7 bit time into the stop bit is still received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 1 | Serial input line, idle High |
| reload_val | input | 16 | Reload number: system clocks per eight bits |
| reload_we | input | 1 | Write strobe for `reload_val` (software or auto-baud source) |
| dbg_mode | input | 1 | Debug mode: use only the low 12 reload bits |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-clock strobe at the mid-stop sample |
| frame_err | output | 1 | Stop sample was Low; valid with `rx_valid` |

## Verification
The assertions check, on every cycle, the following:
- the strobe is one clock wide;
- the error flag is never raised without the strobe;
- two bit ticks never occur back to back;
- a glitch start is dropped to idle;
- the receiver returns to idle in the clock after the stop sample.

The correct bit order, the rate set by the reload number, the 12-bit cut in debug mode, the floor of 4 clocks per bit and the early re-arm are shown only by the bench's scenarios. Those scenarios send frames at exact fractional bit times and compare the reported bytes and flags.

// File: rtl/dbg_serial_rx_pkg.sv
package dbg_serial_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic valid;
        logic ferr;
    } rx_flags_t;

    // A stop sample at Low means the byte was not framed
    function automatic rx_flags_t stop_result(input logic stop_sample);
        rx_flags_t f;
        f.valid = 1'b1;
        f.ferr  = ~stop_sample;
        return f;
    endfunction

endpackage

// File: rtl/dbg_serial_rx_sync.sv
module dbg_serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rxd,
    output logic line,
    output logic fall
);
    logic [STAGES-1:0] sr_q;
    logic              prev_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr_q <= '1;
                else     sr_q <= {sr_q[STAGES-2:0], rxd};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sr_q <= '1;
                else     sr_q <= rxd;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sr_q[STAGES-1];
    end

    assign line = sr_q[STAGES-1];
    assign fall = prev_q & ~sr_q[STAGES-1];
endmodule

// File: rtl/dbg_serial_rx_baud.sv
module dbg_serial_rx_baud #(
    parameter int RELOAD_W   = 16,
    parameter int DBG_W      = 12,
    parameter int STEP       = 8,
    parameter int MIN_RELOAD = 32,
    parameter int RELOAD_RST = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [RELOAD_W-1:0] reload_val,
    input  logic                reload_we,
    input  logic                dbg_mode,
    input  logic                restart,
    input  logic                run,
    output logic                tick
);
    localparam int AW = RELOAD_W + 1;

    logic [RELOAD_W-1:0] reload_q;
    logic [RELOAD_W-1:0] masked;
    logic [RELOAD_W-1:0] eff;
    logic [AW-1:0]       acc_q;
    logic [AW-1:0]       sum;
    logic [AW-1:0]       rem;

    always_ff @(posedge clk) begin
        if (rst)            reload_q <= RELOAD_W'(RELOAD_RST);
        else if (reload_we) reload_q <= reload_val;
    end

    generate
        if (DBG_W < RELOAD_W) begin : g_cut
            assign masked = dbg_mode ? {{(RELOAD_W-DBG_W){1'b0}}, reload_q[DBG_W-1:0]}
                                     : reload_q;
        end else begin : g_full
            assign masked = reload_q;
        end
    endgenerate

    assign eff  = (masked < RELOAD_W'(MIN_RELOAD)) ? RELOAD_W'(MIN_RELOAD) : masked;
    assign sum  = acc_q + AW'(STEP);
    assign rem  = sum - {1'b0, eff};
    assign tick = run && !restart && (sum >= {1'b0, eff});

    always_ff @(posedge clk) begin
        if (rst)          acc_q <= '0;
        else if (restart) acc_q <= {1'b0, eff} >> 1;
        else if (tick)    acc_q <= (rem < AW'(STEP)) ? rem : '0;
        else if (run)     acc_q <= sum;
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick)
        else $error("bit ticks on consecutive clocks");
endmodule

// File: rtl/dbg_serial_rx_frame.sv
module dbg_serial_rx_frame
    import dbg_serial_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line,
    input  logic                 fall,
    input  logic                 tick,
    output logic                 restart,
    output logic                 run,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 frame_err
);
    localparam int CW = $clog2(DATA_BITS + 1);

    rx_state_e            state_q;
    logic [CW-1:0]        cnt_q;
    logic [DATA_BITS-1:0] shreg_q;
    rx_flags_t            flags_q;

    assign restart = (state_q == ST_IDLE) && fall;
    assign run     = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            rx_byte <= '0;
            flags_q <= '0;
        end else begin
            flags_q <= '0;
            case (state_q)
                ST_IDLE: if (fall) state_q <= ST_START;
                ST_START: if (tick) begin
                    cnt_q   <= '0;
                    state_q <= line ? ST_IDLE : ST_DATA;
                end
                ST_DATA: if (tick) begin
                    shreg_q <= {line, shreg_q[DATA_BITS-1:1]};
                    cnt_q   <= cnt_q + 1'b1;
                    if (cnt_q == CW'(DATA_BITS - 1)) state_q <= ST_STOP;
                end
                ST_STOP: if (tick) begin
                    rx_byte <= shreg_q;
                    flags_q <= stop_result(line);
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rx_valid  = flags_q.valid;
    assign frame_err = flags_q.ferr;

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid)
        else $error("valid strobe longer than one clock");
    // R7
    ferr_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> rx_valid)
        else $error("framing error without valid strobe");
    // R8
    glitch_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_START && tick && line) |=> (state_q == ST_IDLE && !rx_valid))
        else $error("glitch start not dropped");
    // R9
    rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STOP && tick) |=> (state_q == ST_IDLE && rx_valid))
        else $error("no re-arm after mid-stop sample");
endmodule

// File: rtl/dbg_serial_rx.sv
module dbg_serial_rx #(
    parameter int RELOAD_W   = 16,
    parameter int DBG_W      = 12,
    parameter int DATA_BITS  = 8,
    parameter int MIN_RELOAD = 32,
    parameter int RELOAD_RST = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rxd,
    input  logic [RELOAD_W-1:0]  reload_val,
    input  logic                 reload_we,
    input  logic                 dbg_mode,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 frame_err
);
    logic line, fall, tick, restart, run;

    dbg_serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .rxd(rxd), .line(line), .fall(fall)
    );

    dbg_serial_rx_baud #(
        .RELOAD_W(RELOAD_W), .DBG_W(DBG_W), .STEP(DATA_BITS),
        .MIN_RELOAD(MIN_RELOAD), .RELOAD_RST(RELOAD_RST)
    ) u_baud (
        .clk(clk), .rst(rst), .reload_val(reload_val), .reload_we(reload_we),
        .dbg_mode(dbg_mode), .restart(restart), .run(run), .tick(tick)
    );

    dbg_serial_rx_frame #(.DATA_BITS(DATA_BITS)) u_frame (
        .clk(clk), .rst(rst), .line(line), .fall(fall), .tick(tick),
        .restart(restart), .run(run), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .frame_err(frame_err)
    );
endmodule

// File: tb/dbg_serial_rx_tb.sv
`timescale 1ns/100ps
module dbg_serial_rx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rxd = 1'b1;
    logic [15:0] reload_val = '0;
    logic        reload_we = 1'b0;
    logic        dbg_mode = 1'b0;
    logic [7:0]  rx_byte;
    logic        rx_valid;
    logic        frame_err;

    int total = 0;
    int bad = 0;
    int rec_n = 0;
    logic [7:0] rec_byte [0:63];
    logic       rec_ferr [0:63];
    logic       last_v = 1'b0;
    int         cycles = 0;

    always #2.5 clk = ~clk;

    dbg_serial_rx u_dut (
        .clk(clk), .rst(rst), .rxd(rxd), .reload_val(reload_val),
        .reload_we(reload_we), .dbg_mode(dbg_mode), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .frame_err(frame_err)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: records frames, checks strobe width (R6)
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid && rec_n < 64) begin
                rec_byte[rec_n] = rx_byte;
                rec_ferr[rec_n] = frame_err;
                rec_n++;
            end
            if (rx_valid && last_v) check(1'b0, "R6 strobe width", 2, 1);
            if (frame_err && !rx_valid) check(1'b0, "R7 flag without strobe", 1, 0);
            last_v = rx_valid;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                check(1'b0, "watchdog", cycles, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic hold(input logic lvl, input int n);
        rxd = lvl;
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Bit i spans clocks (i*r)/8 .. ((i+1)*r)/8 from the start edge
    task automatic send_frame(input logic [7:0] b, input int r, input int stop_len,
                              input logic stop_lvl, input int gap);
        for (int i = 0; i < 9; i++)
            hold((i == 0) ? 1'b0 : b[i-1], ((i + 1) * r) / 8 - (i * r) / 8);
        hold(stop_lvl, (stop_len > 0) ? stop_len : (10 * r) / 8 - (9 * r) / 8);
        if (gap > 0) hold(1'b1, gap);
        else rxd = 1'b1;
    endtask

    task automatic set_reload(input logic [15:0] v, input logic dbg);
        reload_val = v;
        dbg_mode   = dbg;
        reload_we  = 1'b1;
        @(posedge clk);
        #1;
        reload_we  = 1'b0;
    endtask

    task automatic expect_frame(input int idx, input logic [7:0] b, input logic fe,
                                input string req);
        check(rec_n > idx, {req, " frame count"}, rec_n, idx + 1);
        if (rec_n > idx) begin
            check(rec_byte[idx] == b, {req, " byte"}, rec_byte[idx], b);
            check(rec_ferr[idx] == fe, {req, " framing flag"}, rec_ferr[idx], fe);
        end
    endtask

    function automatic int clocks_per_bit2(input int r);
        return (r < 32) ? 32 : r;
    endfunction

    initial begin
        int base;
        logic [7:0] rb;
        int rr;
        void'($urandom(32'h5eed_0042));
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        check(frame_err == 1'b0, "R1 frame_err", frame_err, 0);
        check(rx_byte == 8'h00, "R1 rx_byte", rx_byte, 0);
        @(posedge clk);
        #1;

        // R1/R6: default reload 128, LSB first byte
        send_frame(8'hA5, 128, 0, 1'b1, 40);
        expect_frame(0, 8'hA5, 1'b0, "R1 R6 default rate");

        // R5: new rate by write
        set_reload(16'd200, 1'b0);
        send_frame(8'h3C, 200, 0, 1'b1, 60);
        expect_frame(1, 8'h3C, 1'b0, "R5 rewrite");

        // R3: debug mode keeps only low 12 bits (0x1080 -> 0x080)
        set_reload(16'h1080, 1'b1);
        send_frame(8'h81, 128, 0, 1'b1, 40);
        expect_frame(2, 8'h81, 1'b0, "R3 debug cut");
        // R3: full 16 bits when not in debug mode
        set_reload(16'd4200, 1'b0);
        send_frame(8'h5E, 4200, 0, 1'b1, 1100);
        expect_frame(3, 8'h5E, 1'b0, "R3 full width");

        // R4: reload 8 floors to 32, four clocks per bit
        set_reload(16'd8, 1'b0);
        send_frame(8'hC3, clocks_per_bit2(8), 0, 1'b1, 12);
        expect_frame(4, 8'hC3, 1'b0, "R4 floor");
        set_reload(16'd0, 1'b1);
        send_frame(8'h6D, 32, 0, 1'b1, 12);
        expect_frame(5, 8'h6D, 1'b0, "R4 floor zero");

        // R7: low stop bit
        set_reload(16'd160, 1'b0);
        send_frame(8'h96, 160, 0, 1'b0, 60);
        expect_frame(6, 8'h96, 1'b1, "R7 framing error");
        send_frame(8'h17, 160, 0, 1'b1, 60);
        expect_frame(7, 8'h17, 1'b0, "R7 good after error");

        // R8: short low glitches are dropped
        base = rec_n;
        hold(1'b0, 1); hold(1'b1, 60);
        hold(1'b0, 5); hold(1'b1, 60);
        check(rec_n == base, "R8 glitch ignored", rec_n, base);
        send_frame(8'hE1, 160, 0, 1'b1, 60);
        expect_frame(base, 8'hE1, 1'b0, "R8 frame after glitch");

        // R9: stop bit cut to 0.7 bit, next start follows at once
        base = rec_n;
        send_frame(8'h4B, 160, 14, 1'b1, 0);
        send_frame(8'hB4, 160, 14, 1'b1, 0);
        send_frame(8'hFF, 160, 14, 1'b1, 60);
        expect_frame(base,     8'h4B, 1'b0, "R9 early rearm 1");
        expect_frame(base + 1, 8'hB4, 1'b0, "R9 early rearm 2");
        expect_frame(base + 2, 8'hFF, 1'b0, "R9 early rearm 3");

        // R2/R6: random rates including fractional bit times
        for (int k = 0; k < 24; k++) begin
            if (rec_n >= 60) break;
            rb = 8'($urandom);
            rr = 64 + int'($urandom % 400);
            base = rec_n;
            set_reload(16'(rr), 1'($urandom));
            send_frame(rb, rr, 0, 1'b1, 2 + int'($urandom % 6));
            hold(1'b1, 4);
            expect_frame(base, rb, 1'b0, "R2 R6 random rate");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule